// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences one sampling analog-to-digital converter behind a small parallel register bus. Software sets the enable bit, waits for the reference to settle, then launches a conversion by writing a channel number together with a start bit. The sequencer steps through an input-selection phase and a conversion phase, each a fixed number of serial-clock cycles. It then latches the result, sets a valid flag and emits a one-cycle completion event that an interrupt controller can pick up. With the sync bit set, the sequencer parks after input selection until an external trigger input is high.

The converter itself is a behavioural stub. Its sample is the `stub_level` input plus the selected channel number, modulo 2^10. The bench can therefore tell which channel was latched. All timing is counted in cycles of `clk`, which stands for the serial-bus clock. Parameters fix the warm-up length (`STARTUP_CYC`, default 60 ≈ 5 µs), the selection length (`SEL_CYC`, 51) and the conversion length (`CONV_CYC`, 102).

The state machine has six states. OFF is disabled. WARM runs the reference settling count. READY is idle and enabled. SELECT is input selection. SYNCWAIT waits for the trigger. CONVERT is the conversion. The named transitions are:
- power-up (OFF→WARM, on a control write with enable=1)
- settle (WARM→READY, or WARM→SELECT when a start is pending)
- launch (READY→SELECT)
- route (SELECT→SYNCWAIT if sync is latched, otherwise SELECT→CONVERT)
- trigger (SYNCWAIT→CONVERT)
- finish (CONVERT→READY)
- abort (any state→OFF, on a control write with enable=0)

Top module: `adcseq_top`

## Requirements
- R1: After reset both registers read 0 and `adc_event` is low.
- R2: The control register is at address 0. Bit 0 is enable, bits 3:1 are the channel and bit 4 is sync. Bit 5 is start, which is a strobe and always reads 0. A read returns the last written enable, channel and sync.
- R3: A control write with enable=1 from OFF starts a warm-up of `STARTUP_CYC` cycles. A start written during warm-up, or in the same write as enable, is held. That conversion completes exactly `STARTUP_CYC+SEL_CYC+CONV_CYC` cycles after the enabling write.
- R4: A start written in READY sets the valid flag and pulses `adc_event` exactly `SEL_CYC+CONV_CYC` clock edges after the write edge, and not before.
- R5: The data register is at address 1, with the result in bits 9:0 and the valid flag in bit 15. The result equals `stub_level` plus the channel latched at start, modulo 1024. Channel writes after the start do not change it.
- R6: An accepted start clears the valid flag on its own write edge.
- R7: With sync latched, the sequencer waits indefinitely while `sync_trig` is low. It completes `CONV_CYC` edges after the first edge at which `sync_trig` is seen high while waiting.
- R8: A start written during SELECT, SYNCWAIT or CONVERT is ignored. The running conversion keeps its timing and channel, and produces exactly one event.
- R9: A control write with enable=0 aborts at once. No event follows, valid stays 0, and a later enable needs a fresh warm-up. An abort written on the same edge as completion wins.
- R10: Without sync, a conversion finishes within two bus frames (2×`FRAME_CYC` cycles) of its start.
- R11: `adc_event` is high for exactly one cycle, and only in the cycle in which valid first reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-bus clock; all timing counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 6 | Write data for the control register |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| sync_trig | input | 1 | External conversion trigger, level sensitive |
| stub_level | input | 10 | Value returned by the behavioural converter |
| adc_event | output | 1 | One-cycle completion event |

## Verification
The sharpest collision is a disable write landing on the same edge at which CONVERT would finish. Both the abort and the finish transitions want that edge. The bench counts edges from the start write and places the enable=0 write exactly `SEL_CYC+CONV_CYC` edges later. It then judges that no event appears, that valid stays 0 and that the control register reads 0. A second overlap, a start written while a conversion runs, is judged by the unchanged completion edge, the original channel in the result and a single event.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    // Register addresses on the parallel bus
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    // Fixed field positions
    localparam int EN_POS    = 0;
    localparam int CH_LSB    = 1;
    localparam int RD_W      = 16;
    localparam int VALID_POS = 15;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WARM,
        ST_READY,
        ST_SELECT,
        ST_SYNCWAIT,
        ST_CONVERT
    } seq_state_t;
endpackage

// File: rtl/adcseq_ctrl_regs.sv
module adcseq_ctrl_regs
    import adcseq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int RES_W  = 10,
    parameter int CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    input  logic              valid_q,
    input  logic [RES_W-1:0]  result_q,
    output logic [RD_W-1:0]   bus_rdata,
    output logic              ctrl_we,
    output logic              wr_en,
    output logic              wr_go,
    output logic              wr_sync,
    output logic [CH_W-1:0]   wr_ch
);
    localparam int SYNC_POS = CH_LSB + CH_W;
    localparam int GO_POS   = SYNC_POS + 1;

    logic            en_q;
    logic            sync_q;
    logic [CH_W-1:0] ch_q;

    // Write decode: only the control register is writable
    assign ctrl_we = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_en   = bus_wdata[EN_POS];
    assign wr_go   = bus_wdata[GO_POS];
    assign wr_sync = bus_wdata[SYNC_POS];
    assign wr_ch   = bus_wdata[CH_LSB +: CH_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sync_q <= 1'b0;
            ch_q   <= '0;
        end else if (ctrl_we) begin
            en_q   <= wr_en;
            sync_q <= wr_sync;
            ch_q   <= wr_ch;
        end
    end

    // Read multiplexer; the start strobe is never stored
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_DATA) begin
            bus_rdata[VALID_POS]   = valid_q;
            bus_rdata[RES_W-1:0]   = result_q;
        end else begin
            bus_rdata[EN_POS]          = en_q;
            bus_rdata[CH_LSB +: CH_W]  = ch_q;
            bus_rdata[SYNC_POS]        = sync_q;
        end
    end
endmodule

// File: rtl/adcseq_stub.sv
module adcseq_stub #(
    parameter int CH_W  = 3,
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] level,
    input  logic [CH_W-1:0]  channel,
    output logic [RES_W-1:0] sample
);
    // Behavioural converter: programmed level offset by the channel number
    assign sample = level + {{(RES_W-CH_W){1'b0}}, channel};
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int RES_W       = 10,
    parameter int STARTUP_CYC = 60,
    parameter int SEL_CYC     = 51,
    parameter int CONV_CYC    = 102
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             wr_en,
    input  logic             wr_go,
    input  logic             wr_sync,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic             sync_trig,
    input  logic [RES_W-1:0] sample,
    output seq_state_t       state,
    output logic [CH_W-1:0]  conv_ch,
    output logic             valid_q,
    output logic [RES_W-1:0] result_q,
    output logic             event_q
);
    localparam int MAX_A  = (STARTUP_CYC > SEL_CYC) ? STARTUP_CYC : SEL_CYC;
    localparam int MAX_C  = (MAX_A > CONV_CYC) ? MAX_A : CONV_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(SEL_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    seq_state_t      state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic            pend, pend_n;
    logic            lat_sync, lat_sync_n;
    logic [CH_W-1:0] lat_ch, lat_ch_n;
    logic            accept;
    logic            finish;

    assign conv_ch = lat_ch;

    // Next-state and transition decode
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        pend_n     = pend;
        lat_sync_n = lat_sync;
        lat_ch_n   = lat_ch;
        accept     = 1'b0;
        finish     = 1'b0;
        if (ctrl_we && !wr_en) begin
            // abort: disable wins over every other transition
            state_n = ST_OFF;
            cnt_n   = '0;
            pend_n  = 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (ctrl_we) begin
                        state_n = ST_WARM;  // power-up
                        cnt_n   = '0;
                        if (wr_go) begin
                            pend_n     = 1'b1;
                            accept     = 1'b1;
                            lat_ch_n   = wr_ch;
                            lat_sync_n = wr_sync;
                        end
                    end
                end
                ST_WARM: begin
                    if (ctrl_we && wr_go) begin
                        pend_n     = 1'b1;
                        accept     = 1'b1;
                        lat_ch_n   = wr_ch;
                        lat_sync_n = wr_sync;
                    end
                    if (cnt == WARM_LAST) begin
                        state_n = pend_n ? ST_SELECT : ST_READY;  // settle
                        cnt_n   = '0;
                        pend_n  = 1'b0;
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                ST_READY: begin
                    if (ctrl_we && wr_go) begin
                        state_n    = ST_SELECT;  // launch
                        cnt_n      = '0;
                        accept     = 1'b1;
                        lat_ch_n   = wr_ch;
                        lat_sync_n = wr_sync;
                    end
                end
                ST_SELECT: begin
                    if (cnt == SEL_LAST) begin
                        state_n = lat_sync ? ST_SYNCWAIT : ST_CONVERT;  // route
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                ST_SYNCWAIT: begin
                    if (sync_trig) begin
                        state_n = ST_CONVERT;  // trigger
                        cnt_n   = '0;
                    end
                end
                ST_CONVERT: begin
                    if (cnt == CONV_LAST) begin
                        state_n = ST_READY;  // finish
                        cnt_n   = '0;
                        finish  = 1'b1;
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                default: begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            cnt      <= '0;
            pend     <= 1'b0;
            lat_sync <= 1'b0;
            lat_ch   <= '0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            pend     <= pend_n;
            lat_sync <= lat_sync_n;
            lat_ch   <= lat_ch_n;
        end
    end

    // Output register: result, valid flag and completion event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            event_q  <= 1'b0;
        end else begin
            event_q <= finish;
            if (accept) begin
                valid_q <= 1'b0;
            end else if (finish) begin
                valid_q  <= 1'b1;
                result_q <= sample;
            end
        end
    end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int RES_W       = 10,
    parameter int STARTUP_CYC = 60,
    parameter int SEL_CYC     = 51,
    parameter int CONV_CYC    = 102,
    parameter int FRAME_CYC   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [5:0]       bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             sync_trig,
    input  logic [9:0]       stub_level,
    output logic             adc_event
);
    localparam int CTRL_W = CH_LSB + CH_W + 2;

    logic             ctrl_we, wr_en, wr_go, wr_sync;
    logic [CH_W-1:0]  wr_ch;
    logic [CH_W-1:0]  conv_ch;
    logic [RES_W-1:0] sample;
    logic [RES_W-1:0] result_w;
    logic             valid_w;
    seq_state_t       st_w;

    adcseq_ctrl_regs #(.CH_W(CH_W), .RES_W(RES_W), .CTRL_W(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata[CTRL_W-1:0]),
        .valid_q   (valid_w),
        .result_q  (result_w),
        .bus_rdata (bus_rdata),
        .ctrl_we   (ctrl_we),
        .wr_en     (wr_en),
        .wr_go     (wr_go),
        .wr_sync   (wr_sync),
        .wr_ch     (wr_ch)
    );

    adcseq_stub #(.CH_W(CH_W), .RES_W(RES_W)) u_stub (
        .level   (stub_level[RES_W-1:0]),
        .channel (conv_ch),
        .sample  (sample)
    );

    adcseq_fsm #(
        .CH_W(CH_W), .RES_W(RES_W), .STARTUP_CYC(STARTUP_CYC),
        .SEL_CYC(SEL_CYC), .CONV_CYC(CONV_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .wr_en     (wr_en),
        .wr_go     (wr_go),
        .wr_sync   (wr_sync),
        .wr_ch     (wr_ch),
        .sync_trig (sync_trig),
        .sample    (sample),
        .state     (st_w),
        .conv_ch   (conv_ch),
        .valid_q   (valid_w),
        .result_q  (result_w),
        .event_q   (adc_event)
    );
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
    import adcseq_pkg::*;
#(
    parameter int FRAME_CYC = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic       wr_en,
    input logic       wr_go,
    input logic       sync_trig,
    input logic       adc_event,
    input logic       valid_q,
    input seq_state_t state
);
    logic [15:0] busy_cnt;

    // Cycles spent in selection and conversion; trigger waiting excluded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (state == ST_SELECT || state == ST_CONVERT) begin
            if (busy_cnt != 16'hFFFF) busy_cnt <= busy_cnt + 16'd1;
        end else if (state != ST_SYNCWAIT) begin
            busy_cnt <= '0;
        end
    end

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wr_en) |=> (state == ST_OFF && !adc_event));

    assert_warm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM) |=> (state != ST_CONVERT && state != ST_SYNCWAIT));

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && ctrl_we && wr_en && wr_go) |=> (state == ST_SELECT && !valid_q));

    assert_event_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_event |-> valid_q);

    assert_event_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        adc_event |=> !adc_event);

    assert_sync_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNCWAIT && !sync_trig && !(ctrl_we && !wr_en)) |=> (state == ST_SYNCWAIT));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && ctrl_we && wr_en) |=> (state == ST_CONVERT || state == ST_READY));

    assert_frame_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 16'(2 * FRAME_CYC));
endmodule

bind adcseq_top adcseq_checker #(.FRAME_CYC(FRAME_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .wr_en     (wr_en),
    .wr_go     (wr_go),
    .sync_trig (sync_trig),
    .adc_event (adc_event),
    .valid_q   (valid_w),
    .state     (st_w)
);

// File: tb/sim_adcseq_top.sv
`timescale 1ns/1ps
module sim_adcseq_top;
    localparam int STARTUP = 60;
    localparam int SEL     = 51;
    localparam int CONV    = 102;
    localparam int FRAME   = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [5:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sync_trig = 1'b0;
    logic [9:0]  stub_level = '0;
    logic        adc_event;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ev_count = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (adc_event) ev_count = ev_count + 1;

    adcseq_top #(.STARTUP_CYC(STARTUP), .SEL_CYC(SEL), .CONV_CYC(CONV), .FRAME_CYC(FRAME)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_trig(sync_trig),
        .stub_level(stub_level), .adc_event(adc_event)
    );

    task automatic check_eq(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; sync_trig = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a falling edge; the write is taken at the next rising edge
    task automatic wr_ctrl(logic en, logic [2:0] ch, logic sy, logic go);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = {go, sy, ch, en};
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic enable_and_settle();
        int e;
        wr_ctrl(1'b1, 3'd0, 1'b0, 1'b0);
        e = cyc;
        wait_to(e + STARTUP + 1);
    endtask

    task automatic t_reset_and_readback();
        logic [15:0] d;
        do_reset();
        rd(1'b0, d); check_eq("R1 ctrl after reset", d, 0);
        rd(1'b1, d); check_eq("R1 data after reset", d, 0);
        check_eq("R1 event after reset", adc_event, 0);
        wr_ctrl(1'b1, 3'd5, 1'b1, 1'b1);
        rd(1'b0, d); check_eq("R2 ctrl readback, start reads 0", d, 16'h001B);
    endtask

    task automatic t_normal();
        logic [15:0] d;
        int k;
        do_reset();
        enable_and_settle();
        stub_level = 10'd300;
        wr_ctrl(1'b1, 3'd4, 1'b0, 1'b0);
        wr_ctrl(1'b1, 3'd4, 1'b0, 1'b1);
        k = cyc;
        wait_to(k + SEL + CONV - 1);
        rd(1'b1, d); check_eq("R4 valid not early", d[15], 0);
        check_eq("R4 event not early", adc_event, 0);
        wait_to(k + SEL + CONV);
        rd(1'b1, d); check_eq("R4 valid on time", d[15], 1);
        check_eq("R5 result level+channel", d[9:0], 304);
        check_eq("R11 event with valid", adc_event, 1);
        check_eq("R10 within two frames", ((SEL + CONV) <= 2 * FRAME) ? 1 : 0, 1);
        wait_to(k + SEL + CONV + 1);
        check_eq("R11 event one cycle", adc_event, 0);
        // second conversion: wraps, and a channel change mid-way is not used
        stub_level = 10'd1020;
        wr_ctrl(1'b1, 3'd7, 1'b0, 1'b1);
        k = cyc;
        rd(1'b1, d); check_eq("R6 start clears valid", d[15], 0);
        wait_to(k + 5);
        wr_ctrl(1'b1, 3'd1, 1'b0, 1'b0);
        wait_to(k + SEL + CONV);
        rd(1'b1, d); check_eq("R5 latched channel, wrap", d[9:0], 3);
        check_eq("R5 valid after second", d[15], 1);
        rd(1'b0, d); check_eq("R2 ctrl shows later channel", d, 16'h0003);
    endtask

    task automatic t_warm_pending();
        logic [15:0] d;
        int e;
        do_reset();
        stub_level = 10'd100;
        wr_ctrl(1'b1, 3'd0, 1'b0, 1'b0);
        e = cyc;
        wait_to(e + 10);
        wr_ctrl(1'b1, 3'd2, 1'b0, 1'b1);
        wait_to(e + STARTUP + SEL + CONV - 1);
        rd(1'b1, d); check_eq("R3 held start not early", d[15], 0);
        wait_to(e + STARTUP + SEL + CONV);
        rd(1'b1, d); check_eq("R3 held start completes", d[15], 1);
        check_eq("R3 held start result", d[9:0], 102);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] d;
        int k, ev0;
        do_reset();
        enable_and_settle();
        stub_level = 10'd50;
        wr_ctrl(1'b1, 3'd1, 1'b0, 1'b1);
        k = cyc; ev0 = ev_count;
        wait_to(k + 50);
        wr_ctrl(1'b1, 3'd6, 1'b0, 1'b1);
        wait_to(k + SEL + CONV);
        rd(1'b1, d); check_eq("R8 timing kept", d[15], 1);
        check_eq("R8 original channel", d[9:0], 51);
        wait_to(k + 400);
        check_eq("R8 single event", ev_count - ev0, 1);
    endtask

    task automatic t_sync();
        logic [15:0] d;
        int k, ev0, j;
        do_reset();
        enable_and_settle();
        stub_level = 10'd7;
        wr_ctrl(1'b1, 3'd0, 1'b1, 1'b1);
        k = cyc; ev0 = ev_count;
        wait_to(k + 600);
        rd(1'b1, d); check_eq("R7 waits for trigger", d[15], 0);
        check_eq("R7 no event while waiting", ev_count - ev0, 0);
        sync_trig = 1'b1;
        j = cyc + 1;
        wait_to(j + CONV - 1);
        rd(1'b1, d); check_eq("R7 not before conversion", d[15], 0);
        wait_to(j + CONV);
        rd(1'b1, d); check_eq("R7 done after trigger", d[15], 1);
        check_eq("R7 result", d[9:0], 7);
        sync_trig = 1'b0;
    endtask

    task automatic t_abort();
        logic [15:0] d;
        int k, ev0, e;
        do_reset();
        enable_and_settle();
        wr_ctrl(1'b1, 3'd3, 1'b0, 1'b1);
        k = cyc; ev0 = ev_count;
        wait_to(k + 80);
        wr_ctrl(1'b0, 3'd0, 1'b0, 1'b0);
        wait_to(k + 400);
        check_eq("R9 no event after abort", ev_count - ev0, 0);
        rd(1'b1, d); check_eq("R9 valid stays 0", d[15], 0);
        rd(1'b0, d); check_eq("R9 ctrl cleared", d, 0);
        stub_level = 10'd20;
        wr_ctrl(1'b1, 3'd2, 1'b0, 1'b1);
        e = cyc;
        wait_to(e + STARTUP + SEL + CONV - 1);
        rd(1'b1, d); check_eq("R3 fresh warm-up after abort", d[15], 0);
        wait_to(e + STARTUP + SEL + CONV);
        rd(1'b1, d); check_eq("R3 enable+start same write", d[9:0], 22);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        int k, ev0;
        do_reset();
        enable_and_settle();
        wr_ctrl(1'b1, 3'd0, 1'b0, 1'b1);
        k = cyc; ev0 = ev_count;
        wait_to(k + SEL + CONV - 1);
        wr_ctrl(1'b0, 3'd0, 1'b0, 1'b0);
        check_eq("R9 abort beats finish: event", adc_event, 0);
        rd(1'b1, d); check_eq("R9 abort beats finish: valid", d[15], 0);
        wait_to(k + SEL + CONV + 10);
        check_eq("R9 abort beats finish: no late event", ev_count - ev0, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_and_readback();
        t_normal();
        t_warm_pending();
        t_busy_ignore();
        t_sync();
        t_abort();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule